// File: doc/BRIEF.md
# Chained Command Descriptor Sequencer

This block is the control sequencer of a memory-mapped signal-processing accelerator. A host programs a small register set: a global control word, a sticky status word, an interrupt mask, and an operation window of ten words. The first window word holds the current-command enable, the next-command enable and a word-aligned pointer to the next descriptor. The second window word holds the descriptor length. A host write to the first window word starts the sequencer. It runs the current command through a start/done handshake with an external arithmetic engine.

When the next-command enable is set, the sequencer reads the next descriptor from system memory one 32-bit word at a time over a simple read bus. It copies the descriptor words in order into the operation window, beginning at the first window word. It then acts on the freshly loaded enables: it runs the loaded command, fetches again, or returns to idle. In this way commands form a chain in memory that runs without the host. Completion and error events are kept as sticky status bits, and an interrupt line combines those bits with a mask.

Top module: `cmdchain_seq`

## Requirements
- R1: After reset every register reads 0, and `irq`, `bus_req` and `eng_start` are low.
- R2: Global control word (word 0) holds a halt bit at bit 31 and an enable bit at bit 0. While the halt bit is 1, the status word is cleared, the sequencer is forced to idle, and starts are ignored. Enable acts only while the halt bit is 0. With enable 0, starts are ignored.
- R3: A host write to word 8 while idle, enabled and not halted is a start. If word 8 bit 0 (current enable) is 1, `eng_start` is high for exactly one cycle. That cycle is the second cycle after the write edge.
- R4: `eng_done` while the engine runs sets status bit 0. If word 8 bit 1 (next enable) is 0, the sequencer then returns to idle.
- R5: A fetch reads word k of the descriptor from byte address {word8[31:2], 2'b00} + 4k, for k from 0 upward. It loads word k into window word 8+k. When the start finds bit 0 clear and bit 1 set, the first request is issued in the cycle after the start decision, with no engine run.
- R6: The descriptor length is word 9 bits 7:0, counted in words and latched when the fetch begins. Words with k of 10 or more are read but discarded. A length of 0 issues no bus request, sets status bit 1 and returns to idle.
- R7: Status bit 1 is set when the last descriptor word arrives. The sequencer then acts on the loaded word 8: bit 0 set runs the command, bit 0 clear with bit 1 set fetches again, and both clear means idle.
- R8: `bus_rerr` on an accepted fetch word sets status bit 4. It drops that word, stops the chain, and returns to idle without pulsing `eng_start`.
- R9: An `eng_rd_err` pulse sets status bit 3, and an `eng_wr_err` pulse sets status bit 5.
- R10: Status bits are sticky and are cleared by writing 1s to word 1. A set event in the same cycle as its clear leaves the bit set.
- R11: The interrupt mask is word 2. `irq` is high exactly when some status bit is 1 and the mask bit in the same position is 1.
- R12: Host writes to the window (words 8 to 17) are ignored while the sequencer is not idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 6 | Host register word index (read and write) |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| bus_req | output | 1 | Descriptor word read request, held until accepted |
| bus_addr | output | 32 | Byte address of the requested word |
| bus_rvalid | input | 1 | Read response; the word is accepted at an edge where `bus_req` and `bus_rvalid` are both high |
| bus_rdata | input | 32 | Read data |
| bus_rerr | input | 1 | Read error, qualified by `bus_rvalid` |
| eng_start | output | 1 | One-cycle start to the arithmetic engine |
| eng_done | input | 1 | Engine completion pulse |
| eng_rd_err | input | 1 | Engine data read error pulse |
| eng_wr_err | input | 1 | Engine data write error pulse |
| irq | output | 1 | Masked OR of the status bits |

## Verification
A start is registered at the write edge and decided one edge later. So `eng_start` is sampled low in the half cycle after the write, high one cycle later, and low again after that. For a fetch-first start, `bus_req` and `bus_addr` are checked at that same second sample point. A status bit set by an input pulse is visible one cycle after the edge that captures the pulse, and `irq` follows the status and mask registers with no further delay. Longer chains, with one cycle per accepted word plus two per engine run, are checked only after a settling window of fixed length. Starts and accepted bus addresses are counted by a monitor that samples on the falling edge.

// File: rtl/cmdchain_pkg.sv
// Shared definitions for the command-chain sequencer: state encoding,
// register word indices and status bit positions.
package cmdchain_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECIDE,
        ST_START,
        ST_WAIT,
        ST_FETCH
    } seq_state_t;

    // Register word indices (host address is a word index).
    localparam int WIDX_GCTRL  = 0;
    localparam int WIDX_STATUS = 1;
    localparam int WIDX_IRQEN  = 2;
    localparam int WIDX_WIN    = 8;

    // Status bit positions, shared by the interrupt mask.
    localparam int BIT_DONE     = 0;
    localparam int BIT_LOADED   = 1;
    localparam int BIT_RDERR    = 3;
    localparam int BIT_FETCHERR = 4;
    localparam int BIT_WRERR    = 5;

    localparam int STAT_W = 8;
    localparam logic [STAT_W-1:0] STAT_IMPL = 8'h3B;

endpackage

// File: rtl/cmdchain_regs.sv
// Host register file: global control, interrupt mask and the operation
// window. Window words are written by the host only while the sequencer
// is idle; descriptor loads from the sequencer always take priority.
// Assumes reg_addr is a word index and reads are combinational.
module cmdchain_regs
    import cmdchain_pkg::*;
#(
    parameter int AW        = 6,
    parameter int WIN_WORDS = 10,
    parameter int LEN_W     = 8,
    localparam int IDX_W    = $clog2(WIN_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [AW-1:0]     host_addr,
    input  logic [31:0]       host_wdata,
    input  logic              seq_idle,
    input  logic              ld_we,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [31:0]       ld_data,
    input  logic [STAT_W-1:0] status_in,
    output logic [31:0]       rdata,
    output logic              halt,
    output logic              enable,
    output logic [STAT_W-1:0] irq_mask,
    output logic [31:0]       op_ctrl,
    output logic [LEN_W-1:0]  cmd_len
);

    logic [31:0] win [WIN_WORDS];
    logic [31:0] cmd_word;

    // Global control: halt and enable bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt   <= 1'b0;
            enable <= 1'b0;
        end else if (host_we && host_addr == AW'(WIDX_GCTRL)) begin
            halt   <= host_wdata[31];
            enable <= host_wdata[0];
        end
    end

    // Interrupt mask, only implemented positions stored.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_mask <= '0;
        else if (host_we && host_addr == AW'(WIDX_IRQEN))
            irq_mask <= host_wdata[STAT_W-1:0] & STAT_IMPL;
    end

    // Operation window: descriptor load first, host write while idle second.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WIN_WORDS; i++) win[i] <= '0;
        end else begin
            for (int i = 0; i < WIN_WORDS; i++) begin
                if (ld_we && ld_idx == IDX_W'(i))
                    win[i] <= ld_data;
                else if (host_we && seq_idle && host_addr == AW'(WIDX_WIN + i))
                    win[i] <= host_wdata;
            end
        end
    end

    assign op_ctrl  = win[0];
    assign cmd_word = win[1];
    assign cmd_len  = cmd_word[LEN_W-1:0];

    // Read-back multiplexer.
    always_comb begin
        rdata = '0;
        if (host_addr == AW'(WIDX_GCTRL))
            rdata = {halt, 30'b0, enable};
        else if (host_addr == AW'(WIDX_STATUS))
            rdata = {{(32-STAT_W){1'b0}}, status_in};
        else if (host_addr == AW'(WIDX_IRQEN))
            rdata = {{(32-STAT_W){1'b0}}, irq_mask};
        for (int i = 0; i < WIN_WORDS; i++)
            if (host_addr == AW'(WIDX_WIN + i)) rdata = win[i];
    end

endmodule

// File: rtl/cmdchain_status.sv
// Sticky status bits with write-one-to-clear and a masked interrupt.
// A set event wins over a clear in the same cycle; halt clears all.
module cmdchain_status
    import cmdchain_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  logic [STAT_W-1:0] set_vec,
    input  logic              w1c_we,
    input  logic [STAT_W-1:0] w1c_bits,
    input  logic [STAT_W-1:0] irq_mask,
    output logic [STAT_W-1:0] status,
    output logic              irq
);

    logic [STAT_W-1:0] clr_vec;

    assign clr_vec = w1c_we ? w1c_bits : '0;

    // Status update: clear-all, then set-over-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status <= '0;
        else if (clr_all)
            status <= '0;
        else
            status <= ((status & ~clr_vec) | set_vec) & STAT_IMPL;
    end

    assign irq = |(status & irq_mask);

endmodule

// File: rtl/cmdchain_fsm.sv
// Sequencer state machine: decides between running the engine and
// fetching the next descriptor, issues one word read at a time, and
// loads accepted words into the operation window. Fetch pointer and
// length are latched on fetch entry because the load overwrites them.
module cmdchain_fsm
    import cmdchain_pkg::*;
#(
    parameter int WIN_WORDS = 10,
    parameter int LEN_W     = 8,
    localparam int IDX_W    = $clog2(WIN_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt,
    input  logic             kick,
    input  logic [31:0]      op_ctrl,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic             eng_done,
    input  logic             bus_rvalid,
    input  logic [31:0]      bus_rdata,
    input  logic             bus_rerr,
    output seq_state_t       state,
    output logic             eng_start,
    output logic             bus_req,
    output logic [31:0]      bus_addr,
    output logic             ld_we,
    output logic [IDX_W-1:0] ld_idx,
    output logic [31:0]      ld_data,
    output logic             set_done,
    output logic             set_loaded,
    output logic             set_fetch_err
);

    localparam logic [LEN_W:0] WIN_LIM = (LEN_W+1)'(WIN_WORDS);

    seq_state_t       nxt;
    logic             latch;
    logic [29:0]      base_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] cnt_q;
    logic             take;
    logic             last;
    logic             len_zero;

    assign len_zero = (len_q == '0);
    assign take     = bus_req && bus_rvalid;
    assign last     = (cnt_q == len_q - 1'b1);

    // Next-state selection.
    always_comb begin
        nxt   = state;
        latch = 1'b0;
        unique case (state)
            ST_IDLE:   if (kick) nxt = ST_DECIDE;
            ST_DECIDE: begin
                if (op_ctrl[0]) nxt = ST_START;
                else if (op_ctrl[1]) begin
                    nxt   = ST_FETCH;
                    latch = 1'b1;
                end else nxt = ST_IDLE;
            end
            ST_START:  nxt = ST_WAIT;
            ST_WAIT: begin
                if (eng_done) begin
                    if (op_ctrl[1]) begin
                        nxt   = ST_FETCH;
                        latch = 1'b1;
                    end else nxt = ST_IDLE;
                end
            end
            ST_FETCH: begin
                if (len_zero) nxt = ST_IDLE;
                else if (take) begin
                    if (bus_rerr) nxt = ST_IDLE;
                    else if (last) nxt = ST_DECIDE;
                end
            end
            default:   nxt = ST_IDLE;
        endcase
        if (halt) begin
            nxt   = ST_IDLE;
            latch = 1'b0;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Fetch pointer, length and word counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            len_q  <= '0;
            cnt_q  <= '0;
        end else if (latch) begin
            base_q <= op_ctrl[31:2];
            len_q  <= cmd_len;
            cnt_q  <= '0;
        end else if (take && !bus_rerr) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign eng_start     = (state == ST_START);
    assign bus_req       = (state == ST_FETCH) && !len_zero;
    assign bus_addr      = {base_q + 30'(cnt_q), 2'b00};
    assign ld_we         = take && !bus_rerr && ({1'b0, cnt_q} < WIN_LIM);
    assign ld_idx        = cnt_q[IDX_W-1:0];
    assign ld_data       = bus_rdata;
    assign set_done      = (state == ST_WAIT) && eng_done;
    assign set_fetch_err = take && bus_rerr;
    assign set_loaded    = ((state == ST_FETCH) && len_zero) ||
                           (take && !bus_rerr && last);

endmodule

// File: rtl/cmdchain_seq.sv
// Top of the command-chain sequencer. Connects the register file, the
// state machine and the status/interrupt logic, and decodes the start
// write. Assumes one outstanding descriptor read at a time.
module cmdchain_seq
    import cmdchain_pkg::*;
#(
    parameter int AW        = 6,
    parameter int WIN_WORDS = 10,
    parameter int LEN_W     = 8,
    localparam int IDX_W    = $clog2(WIN_WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          bus_req,
    output logic [31:0]   bus_addr,
    input  logic          bus_rvalid,
    input  logic [31:0]   bus_rdata,
    input  logic          bus_rerr,
    output logic          eng_start,
    input  logic          eng_done,
    input  logic          eng_rd_err,
    input  logic          eng_wr_err,
    output logic          irq
);

    seq_state_t        seq_state;
    logic              srst;
    logic              gen;
    logic [STAT_W-1:0] irq_mask;
    logic [STAT_W-1:0] status_v;
    logic [STAT_W-1:0] set_vec;
    logic [31:0]       op_ctrl;
    logic [LEN_W-1:0]  cmd_len;
    logic              ld_we;
    logic [IDX_W-1:0]  ld_idx;
    logic [31:0]       ld_data;
    logic              set_done;
    logic              set_loaded;
    logic              set_fetch_err;
    logic              kick;
    logic              w1c_we;

    assign kick   = reg_wr && reg_addr == AW'(WIDX_WIN) && gen && !srst;
    assign w1c_we = reg_wr && reg_addr == AW'(WIDX_STATUS);

    // Gather the set events into status positions.
    always_comb begin
        set_vec               = '0;
        set_vec[BIT_DONE]     = set_done;
        set_vec[BIT_LOADED]   = set_loaded;
        set_vec[BIT_RDERR]    = eng_rd_err;
        set_vec[BIT_FETCHERR] = set_fetch_err;
        set_vec[BIT_WRERR]    = eng_wr_err;
    end

    cmdchain_regs #(.AW(AW), .WIN_WORDS(WIN_WORDS), .LEN_W(LEN_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (reg_wr),
        .host_addr  (reg_addr),
        .host_wdata (reg_wdata),
        .seq_idle   (seq_state == ST_IDLE),
        .ld_we      (ld_we),
        .ld_idx     (ld_idx),
        .ld_data    (ld_data),
        .status_in  (status_v),
        .rdata      (reg_rdata),
        .halt       (srst),
        .enable     (gen),
        .irq_mask   (irq_mask),
        .op_ctrl    (op_ctrl),
        .cmd_len    (cmd_len)
    );

    cmdchain_fsm #(.WIN_WORDS(WIN_WORDS), .LEN_W(LEN_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .halt          (srst),
        .kick          (kick),
        .op_ctrl       (op_ctrl),
        .cmd_len       (cmd_len),
        .eng_done      (eng_done),
        .bus_rvalid    (bus_rvalid),
        .bus_rdata     (bus_rdata),
        .bus_rerr      (bus_rerr),
        .state         (seq_state),
        .eng_start     (eng_start),
        .bus_req       (bus_req),
        .bus_addr      (bus_addr),
        .ld_we         (ld_we),
        .ld_idx        (ld_idx),
        .ld_data       (ld_data),
        .set_done      (set_done),
        .set_loaded    (set_loaded),
        .set_fetch_err (set_fetch_err)
    );

    cmdchain_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_all  (srst),
        .set_vec  (set_vec),
        .w1c_we   (w1c_we),
        .w1c_bits (reg_wdata[STAT_W-1:0]),
        .irq_mask (irq_mask),
        .status   (status_v),
        .irq      (irq)
    );

endmodule

// File: rtl/cmdchain_seq_chk.sv
// Protocol checker for the command-chain sequencer, bound to the top.
// Observes ports plus the halt bit, state and status word.
module cmdchain_seq_chk
    import cmdchain_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        srst,
    input seq_state_t  seq_state,
    input logic [7:0]  status_v,
    input logic        eng_start,
    input logic        eng_done,
    input logic        bus_req,
    input logic [31:0] bus_addr,
    input logic        bus_rvalid,
    input logic        bus_rerr
);

    // R3: engine start is a single-cycle pulse.
    a_r3_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    // R8: a failed descriptor read stops the chain at once.
    a_r8_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_rvalid && bus_rerr) |=> (!bus_req && !eng_start));

    // R5: an unaccepted request keeps its address.
    a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_rvalid && !srst) |=> (bus_req && $stable(bus_addr)));

    // R2: halt forces idle and clears status.
    a_r2_halt_idle: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (!bus_req && !eng_start && status_v == 8'h00));

    // R4: engine completion is recorded.
    a_r4_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_WAIT && eng_done && !srst) |=> status_v[BIT_DONE]);

endmodule

bind cmdchain_seq cmdchain_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .srst       (srst),
    .seq_state  (seq_state),
    .status_v   (status_v),
    .eng_start  (eng_start),
    .eng_done   (eng_done),
    .bus_req    (bus_req),
    .bus_addr   (bus_addr),
    .bus_rvalid (bus_rvalid),
    .bus_rerr   (bus_rerr)
);

// File: tb/cmdchain_seq_test.sv
// Directed bench for the command-chain sequencer.
module cmdchain_seq_test;

    localparam logic [5:0] A_GCTRL = 6'd0;
    localparam logic [5:0] A_STAT  = 6'd1;
    localparam logic [5:0] A_MASK  = 6'd2;
    localparam logic [5:0] A_OPC   = 6'd8;
    localparam logic [5:0] A_CMD   = 6'd9;
    localparam logic [5:0] A_W2    = 6'd10;
    localparam logic [5:0] A_W9    = 6'd17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        bus_req;
    logic [31:0] bus_addr;
    logic        bus_rvalid = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic        bus_rerr = 1'b0;
    logic        eng_start;
    logic        eng_done = 1'b0;
    logic        eng_rd_err = 1'b0;
    logic        eng_wr_err = 1'b0;
    logic        irq;

    int          checks = 0;
    int          failures = 0;
    int          start_cnt = 0;
    int          fetch_cnt = 0;
    logic [31:0] fetch_log [16];
    logic [31:0] mem [64];
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    int          eng_lat = 3;
    int          eng_cnt = 0;

    always #10 clk = ~clk;

    cmdchain_seq uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req),
        .bus_addr(bus_addr), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .bus_rerr(bus_rerr), .eng_start(eng_start), .eng_done(eng_done),
        .eng_rd_err(eng_rd_err), .eng_wr_err(eng_wr_err), .irq(irq)
    );

    // Memory and engine models, plus the start/fetch monitor.
    always @(negedge clk) begin
        bus_rvalid <= bus_req;
        bus_rerr   <= bus_req && (bus_addr == err_addr);
        bus_rdata  <= mem[bus_addr[7:2]];
        if (bus_req) begin
            if (fetch_cnt < 16) fetch_log[fetch_cnt] = bus_addr;
            fetch_cnt = fetch_cnt + 1;
        end
        eng_done <= 1'b0;
        if (eng_cnt > 0) begin
            eng_cnt = eng_cnt - 1;
            if (eng_cnt == 0) eng_done <= 1'b1;
        end
        if (eng_start) begin
            start_cnt = start_cnt + 1;
            eng_cnt   = eng_lat;
        end
    end

    task automatic check(input logic ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic expect_reg(input logic [5:0] a, input logic [31:0] e, input string req);
        logic [31:0] d;
        rd(a, d);
        check(d === e, req, d, e);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fresh();
        wr(A_STAT, 32'hFF);
        start_cnt = 0;
        fetch_cnt = 0;
    endtask

    task automatic t_reset();
        check(irq === 1'b0, "R1 irq", 32'(irq), 0);
        check(bus_req === 1'b0, "R1 bus_req", 32'(bus_req), 0);
        check(eng_start === 1'b0, "R1 eng_start", 32'(eng_start), 0);
        expect_reg(A_GCTRL, 0, "R1 gctrl");
        expect_reg(A_STAT, 0, "R1 status");
        expect_reg(A_MASK, 0, "R1 mask");
        expect_reg(A_OPC, 0, "R1 window");
    endtask

    task automatic t_single();
        fresh();
        wr(A_CMD, 32'h0);
        wr(A_OPC, 32'h1);
        check(eng_start === 1'b0, "R3 start not yet", 32'(eng_start), 0);
        @(negedge clk);
        check(eng_start === 1'b1, "R3 start pulse", 32'(eng_start), 1);
        @(negedge clk);
        check(eng_start === 1'b0, "R3 start one cycle", 32'(eng_start), 0);
        settle(8);
        expect_reg(A_STAT, 32'h01, "R4 done bit");
        check(fetch_cnt == 0, "R4 no fetch", 32'(fetch_cnt), 0);
        check(start_cnt == 1, "R4 one run", 32'(start_cnt), 1);
        wr(A_MASK, 32'h02);
        check(irq === 1'b0, "R11 other position", 32'(irq), 0);
        wr(A_MASK, 32'h01);
        check(irq === 1'b1, "R11 irq raised", 32'(irq), 1);
        wr(A_STAT, 32'h01);
        check(irq === 1'b0, "R10 cleared", 32'(irq), 0);
        wr(A_MASK, 32'h0);
    endtask

    task automatic t_chain();
        fresh();
        mem[16] = 32'h1; mem[17] = 32'h0; mem[18] = 32'hA5A5_0003;
        wr(A_CMD, 32'd3);
        wr(A_OPC, 32'h43);
        settle(30);
        check(start_cnt == 2, "R7 loaded command ran", 32'(start_cnt), 2);
        check(fetch_cnt == 3, "R5 word count", 32'(fetch_cnt), 3);
        check(fetch_log[0] == 32'h40, "R5 addr0", fetch_log[0], 32'h40);
        check(fetch_log[2] == 32'h48, "R5 addr2", fetch_log[2], 32'h48);
        expect_reg(A_OPC, 32'h1, "R5 word0 loaded");
        expect_reg(A_CMD, 32'h0, "R5 word1 loaded");
        expect_reg(A_W2, 32'hA5A5_0003, "R5 word2 loaded");
        expect_reg(A_STAT, 32'h03, "R7 done and loaded");
    endtask

    task automatic t_fetch_first();
        fresh();
        mem[32] = 32'h0; mem[33] = 32'd12;
        for (int k = 2; k < 12; k++) mem[32+k] = 32'h1000 + 32'(k);
        wr(A_CMD, 32'd12);
        wr(A_OPC, 32'h82);
        check(bus_req === 1'b0, "R5 no request yet", 32'(bus_req), 0);
        @(negedge clk);
        check(bus_req === 1'b1, "R5 immediate fetch", 32'(bus_req), 1);
        check(bus_addr === 32'h80, "R5 first address", bus_addr, 32'h80);
        settle(20);
        check(fetch_cnt == 12, "R6 all words read", 32'(fetch_cnt), 12);
        check(fetch_log[11] == 32'hAC, "R6 last address", fetch_log[11], 32'hAC);
        check(start_cnt == 0, "R7 neither enable", 32'(start_cnt), 0);
        expect_reg(A_W9, 32'h1009, "R6 tenth word kept");
        expect_reg(A_CMD, 32'd12, "R6 length word");
        expect_reg(A_STAT, 32'h02, "R7 loaded only");
    endtask

    task automatic t_zero_len();
        fresh();
        wr(A_CMD, 32'h0);
        wr(A_OPC, 32'h102);
        settle(6);
        check(fetch_cnt == 0, "R6 zero length no request", 32'(fetch_cnt), 0);
        expect_reg(A_STAT, 32'h02, "R6 zero length loaded");
    endtask

    task automatic t_fetch_err();
        fresh();
        mem[48] = 32'h1; mem[49] = 32'h0; mem[50] = 32'h0;
        err_addr = 32'hC4;
        wr(A_CMD, 32'd3);
        wr(A_OPC, 32'hC2);
        settle(10);
        check(start_cnt == 0, "R8 no start", 32'(start_cnt), 0);
        check(fetch_cnt == 2, "R8 stopped at error", 32'(fetch_cnt), 2);
        expect_reg(A_STAT, 32'h10, "R8 error bit");
        expect_reg(A_CMD, 32'd3, "R8 bad word dropped");
        wr(A_MASK, 32'h10);
        check(irq === 1'b1, "R11 fetch error irq", 32'(irq), 1);
        wr(A_MASK, 32'h0);
        err_addr = 32'hFFFF_FFFF;
    endtask

    task automatic t_eng_err();
        fresh();
        @(negedge clk); eng_rd_err = 1'b1;
        @(negedge clk); eng_rd_err = 1'b0;
        expect_reg(A_STAT, 32'h08, "R9 read error");
        @(negedge clk);
        eng_rd_err = 1'b1; reg_wr = 1'b1; reg_addr = A_STAT; reg_wdata = 32'h08;
        @(negedge clk);
        eng_rd_err = 1'b0; reg_wr = 1'b0;
        expect_reg(A_STAT, 32'h08, "R10 set wins");
        wr(A_STAT, 32'h08);
        expect_reg(A_STAT, 32'h00, "R10 w1c");
        @(negedge clk); eng_wr_err = 1'b1;
        @(negedge clk); eng_wr_err = 1'b0;
        expect_reg(A_STAT, 32'h20, "R9 write error");
    endtask

    task automatic t_busy();
        fresh();
        eng_lat = 20;
        wr(A_W2, 32'h11);
        wr(A_CMD, 32'h0);
        wr(A_OPC, 32'h1);
        settle(3);
        wr(A_W2, 32'h22);
        wr(A_OPC, 32'h2);
        expect_reg(A_W2, 32'h11, "R12 window held");
        expect_reg(A_OPC, 32'h1, "R12 control held");
        settle(25);
        check(start_cnt == 1, "R12 single run", 32'(start_cnt), 1);
        expect_reg(A_STAT, 32'h01, "R4 done after long run");
        eng_lat = 3;
    endtask

    task automatic t_soft();
        fresh();
        @(negedge clk); eng_rd_err = 1'b1;
        @(negedge clk); eng_rd_err = 1'b0;
        wr(A_GCTRL, 32'h8000_0001);
        @(negedge clk);
        expect_reg(A_STAT, 32'h0, "R2 status cleared");
        expect_reg(A_GCTRL, 32'h8000_0001, "R2 readback");
        wr(A_OPC, 32'h1);
        settle(6);
        check(start_cnt == 0, "R2 halted no start", 32'(start_cnt), 0);
        wr(A_GCTRL, 32'h0);
        wr(A_OPC, 32'h1);
        settle(6);
        check(start_cnt == 0, "R2 disabled no start", 32'(start_cnt), 0);
        wr(A_GCTRL, 32'h1);
        wr(A_OPC, 32'h1);
        settle(8);
        check(start_cnt == 1, "R2 runs after release", 32'(start_cnt), 1);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        wr(A_GCTRL, 32'h1);
        t_single();
        t_chain();
        t_fetch_first();
        t_zero_len();
        t_fetch_err();
        t_eng_err();
        t_busy();
        t_soft();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule